// File: doc/BRIEF.md
# Dual-Read Register File with Zero Register

This block is the integer register file of a small load/store processor core. It stores 32 words of 32 bits. Two read ports each take a register number and return the word held there. One write port takes a register number, a data word and an enable. Register number 0 is the architectural zero register: whatever its storage cell holds, both read ports return all zeros for it.

Every input is captured in a register on the rising clock edge, including both read numbers and the whole write request. Read data then leaves the storage array through the zero mask with no output register. A captured write reaches storage on the next edge. A read captured in the same edge as a write to the same register therefore still sees the old word. Reset loads a computed boot image, so reads can be exercised before any write. That image deliberately gives register 0 a nonzero cell.

Top module: `dual_read_regfile`

## Requirements
- R1: The file holds 32 registers of 32 bits each, selected by 5-bit register numbers; every one of the 32 numbers reaches a distinct word.
- R2: Storage changes only for a request whose `wr_en` is 1 at the sampling edge; with `wr_en` 0, no read port result changes, whatever `wr_addr` and `wr_data` are.
- R3: A read of register number 0 on either port returns 0x00000000, even when its storage cell holds a nonzero value from reset or from a write to number 0.
- R4: A write request sampled at edge k is returned by any read whose register number is sampled at edge k+1 or later.
- R5: A read number sampled at edge k is answered after edge k with no further clock edge. The answer holds for as long as the number and the addressed word stay the same.
- R6: When a read and a write to the same nonzero register are sampled at the same edge, the read returns the value held before that write.
- R7: While reset is low, both read outputs are zero. On release, register i holds 0xA5000000 XOR (i × 0x01010101) modulo 2^32, so register 0's cell holds 0xA5000000.
- R8: The two read ports are independent: different register numbers on the two ports in the same cycle each return their own register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; loads the boot image |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_addr_b | input | 5 | Register number for read port B |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | 32 | Word to write |
| wr_en | input | 1 | Write request enable |
| rd_data_a | output | 32 | Word returned by read port A |
| rd_data_b | output | 32 | Word returned by read port B |

## Verification
A read and a write can fall in the same cycle on the same register, and the write can also target the zero register. The bench provokes both cases in two ways. A directed sweep writes each register while reading it on both ports in the same cycle. A long random phase steers the read numbers onto the write number about half the time. Every result is judged against a reference array that commits a captured write one edge after capture. This model expects the old word in the collision cycle, the new word from the next read on, and zero for register 0 throughout.

// File: rtl/dual_read_regfile.sv
module dual_read_regfile #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] BOOT_SEED = 32'hA500_0000,
  parameter logic [DATA_W-1:0] BOOT_STEP = 32'h0101_0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b
);

  localparam int NREGS = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [NREGS];
  logic [ADDR_W-1:0] ra_q, rb_q, wa_q;
  logic [DATA_W-1:0] wd_q;
  logic              we_q;

  function automatic logic [DATA_W-1:0] boot_word(input int idx);
    return BOOT_SEED ^ (DATA_W'(idx) * BOOT_STEP);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q <= '0;
      rb_q <= '0;
      wa_q <= '0;
      wd_q <= '0;
      we_q <= 1'b0;
      for (int i = 0; i < NREGS; i++) cells[i] <= boot_word(i);
    end else begin
      ra_q <= rd_addr_a;
      rb_q <= rd_addr_b;
      wa_q <= wr_addr;
      wd_q <= wr_data;
      we_q <= wr_en;
      if (we_q) cells[wa_q] <= wd_q;
    end
  end

  assign rd_data_a = (ra_q == '0) ? '0 : cells[ra_q];
  assign rd_data_b = (rb_q == '0) ? '0 : cells[rb_q];

  // R3: a port sampled at register 0 answers zero
  p_zero_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == '0) |=> (rd_data_a == '0));
  p_zero_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_b == '0) |=> (rd_data_b == '0));

  // R4: a committing write is seen by a read sampled at the commit edge
  p_write_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_q && wa_q != '0 && rd_addr_a == wa_q) |=> (rd_data_a == $past(wd_q)));

  // R6: a same-edge read of the write target returns the old word
  p_old_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !we_q && wr_addr != '0 && rd_addr_b == wr_addr)
      |=> (rd_data_b == $past(cells[wr_addr])));

  // R2 / R5: no commit and same read number keep the answer
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_q && rd_addr_a == ra_q) |=> $stable(rd_data_a));

  // R7: outputs are zero while reset is held
  always_comb begin
    if (!rst_n) a_reset_zero_r7: assert (rd_data_a == '0 && rd_data_b == '0);
  end

endmodule

// File: tb/dual_read_regfile_tb_top.sv
module dual_read_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_en = 1'b0;
  logic [31:0] rd_data_a, rd_data_b;

  int vectors = 0;
  int misses  = 0;

  logic [31:0] model [32];
  logic        pend_en = 1'b0;
  logic [4:0]  pend_addr = '0;
  logic [31:0] pend_data = '0;
  logic [4:0]  cap_a = '0, cap_b = '0;

  always #2.5 clk = ~clk;

  dual_read_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
  );

  function automatic logic [31:0] boot_img(input int i);
    return 32'hA500_0000 ^ (32'(i) * 32'h0101_0101);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    if (pend_en) model[pend_addr] = pend_data;
    pend_en = wr_en; pend_addr = wr_addr; pend_data = wr_data;
    cap_a = rd_addr_a; cap_b = rd_addr_b;
    #1;
    check({tag, " port A"}, rd_data_a, (cap_a == 0) ? 32'h0 : model[cap_a]);
    check({tag, " port B"}, rd_data_b, (cap_b == 0) ? 32'h0 : model[cap_b]);
  endtask

  initial begin
    #1_000_000;
    misses++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = boot_img(i);
    rd_addr_a = 5'd7; rd_addr_b = 5'd9;
    #12;
    check("R7 reset port A", rd_data_a, 32'h0);
    check("R7 reset port B", rd_data_b, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1 R7 R8 R3: boot image sweep, ports crossing
    for (int i = 0; i < 32; i++) begin
      rd_addr_a = 5'(i); rd_addr_b = 5'(31 - i);
      tick("R1 R7 R8 R3 boot sweep");
    end
    check("R7 reg 31 image", model[31], 32'hA500_0000 ^ (32'd31 * 32'h0101_0101));

    // R2: disabled writes everywhere, then reread
    for (int i = 0; i < 32; i++) begin
      wr_en = 1'b0; wr_addr = 5'(i); wr_data = ~boot_img(i);
      rd_addr_a = 5'(i); rd_addr_b = 5'((i + 1) % 32);
      tick("R2 disabled write");
    end
    for (int i = 0; i < 32; i++) begin
      rd_addr_a = 5'(i); rd_addr_b = 5'(i);
      tick("R2 reread");
    end

    // R4 R3: fill all registers including 0, then read back
    for (int i = 0; i < 32; i++) begin
      wr_en = 1'b1; wr_addr = 5'(i); wr_data = 32'(i) * 32'h9E37_79B9 + 32'h1234_5678;
      rd_addr_a = 5'd0; rd_addr_b = 5'((i + 16) % 32);
      tick("R4 R3 fill");
    end
    wr_en = 1'b0;
    for (int i = 0; i < 32; i++) begin
      rd_addr_a = 5'(i); rd_addr_b = 5'(31 - i);
      tick("R4 R3 R1 readback");
    end

    // R6 R4 R5: same-edge collision, then the following read
    for (int i = 0; i < 32; i++) begin
      logic [31:0] old;
      old = model[i];
      wr_en = 1'b1; wr_addr = 5'(i); wr_data = ~old ^ 32'(i << 8);
      rd_addr_a = 5'(i); rd_addr_b = 5'(i);
      tick("R6 collision");
      if (i != 0) check("R6 old word", rd_data_a, old);
      wr_en = 1'b0;
      tick("R4 R5 after collision");
      check("R4 new word", rd_data_b, (i == 0) ? 32'h0 : ~old ^ 32'(i << 8));
    end

    // mixed random traffic, biased towards collisions and register 0
    for (int n = 0; n < 3000; n++) begin
      wr_en   = 1'($urandom_range(1));
      wr_addr = ($urandom_range(7) == 0) ? 5'd0 : 5'($urandom_range(31));
      wr_data = $urandom;
      rd_addr_a = $urandom_range(1) ? wr_addr : 5'($urandom_range(31));
      rd_addr_b = $urandom_range(1) ? pend_addr : 5'($urandom_range(31));
      tick("R2 R3 R4 R6 R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule